// File: doc/BRIEF.md
# Constellation Point Loader for a Numerically Controlled Modulator

This block takes a coded symbol index, finds its in-phase and quadrature amplitudes in two 32-entry tables, and programs an external numerically controlled modulator (NCO) with them. The external device has only one data register port, so the two amplitudes go out one after the other through the same bus. A fixed control word follows them, and that word tells the NCO to apply the new phase and amplitude together. A framing flag, high when idle, stays low for the whole transaction.

A symbol source offers an index with a valid/ready pair. Only the five low bits select a constellation point. Every transaction takes the same number of cycles, whatever the symbol and whatever the table contents. The tables start out with a computed default pattern. While the block is idle, they can be rewritten one entry at a time through a small address/data port.

Top module: `qam_nco_loader`

## Requirements
- R1: While reset is held and in the first cycle after it, `frame_n` is 1, `in_ready` is 1, and `data_we`, `ctrl_we`, `done`, `nco_data` and `nco_ctrl` are all 0.
- R2: The symbol index is the low 5 bits of `in_symbol`, and its upper bits are ignored. For example, 8'hE5 selects entry 5 and 8'hFF selects entry 31.
- R3: Count the accepting clock edge as edge 0. `data_we` is then high for exactly the cycles after edges 2 and 3, and no other data write happens in the transaction. The first of these writes carries the in-phase entry of the selected index on `nco_data`.
- R4: The second data write, after edge 3, carries the quadrature entry of the same index on `nco_data`. `nco_data` keeps its last value when no write is in progress.
- R5: After edge 4, `ctrl_we` is high for one cycle with `nco_ctrl` equal to 11. `data_we` and `ctrl_we` are never high in the same cycle.
- R6: `frame_n` goes low after edge 0 and returns high after edge 5. `done` is a one-cycle pulse in the cycle where `frame_n` returns high. Every write strobe falls inside the low period.
- R7: A symbol is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from acceptance until `frame_n` is high again, and `in_valid` has no effect during that time.
- R8: The transaction length is fixed. With `in_valid` held high, a new symbol is accepted every 6 cycles and `done` pulses repeat every 6 cycles.
- R9: While idle, a rising edge with `tbl_we` = 1 writes `tbl_wdata` into entry `tbl_addr`. The target is the in-phase table when `tbl_sel` = 0 and the quadrature table when `tbl_sel` = 1. A write in the accepting cycle is seen by that transaction.
- R10: `tbl_we` is ignored while a transaction is in progress, and the table contents stay unchanged.
- R11: Before any table write, in-phase entry k holds (k-16)*1024 and quadrature entry k holds (16-k)*512, each as a 16-bit two's complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Symbol offered |
| in_symbol | input | 8 | Coded symbol; the low 5 bits select the point |
| in_ready | output | 1 | Block idle and able to take a symbol |
| tbl_we | input | 1 | Table entry write enable, honoured only when idle |
| tbl_sel | input | 1 | 0 = in-phase table, 1 = quadrature table |
| tbl_addr | input | 5 | Table entry to write |
| tbl_wdata | input | 16 | Signed value to store |
| nco_data | output | 16 | Shared data bus to the modulator |
| data_we | output | 1 | One-cycle data write strobe |
| nco_ctrl | output | 8 | Control bus to the modulator |
| ctrl_we | output | 1 | One-cycle control write strobe |
| frame_n | output | 1 | Transaction framing flag, low while loading |
| done | output | 1 | Pulse when the flag returns high |

## Verification
The bench targets the following corner cases, and for each one it names how a faulty design would show itself:
- Indices with high bits set. A design that failed to mask would read outside the table or pick the wrong point.
- Swapped write order. A design that got the order wrong would put the quadrature value on the bus first.
- Table writes and new symbols arriving in the middle of a transaction. A faulty design would corrupt an entry or restart the sequence early.
- A write in the very cycle a symbol is accepted, which must already show up in that symbol's output.
- Back-to-back symbols with `in_valid` held high. A design with an off-by-one in the state sequence would show a cadence other than 6 cycles or a `done` pulse out of line with the flag.

// File: rtl/qnl_pkg.sv
package qnl_pkg;

  parameter int DATA_W    = 16;
  parameter int POINTS    = 32;
  parameter int IDX_W     = $clog2(POINTS);
  parameter int SYM_W     = 8;
  parameter int CTRL_W    = 8;
  parameter int CTRL_CODE = 11;
  parameter int LANES     = 2;   // lane 0 in-phase, lane 1 quadrature

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_I,
    ST_WR_Q,
    ST_WR_CTRL,
    ST_CLOSE
  } seq_state_t;

  // Default table contents: a linear ramp per lane.
  function automatic logic [DATA_W-1:0] default_entry(input int lane, input int k);
    int v;
    if (lane == 0) v = (k - POINTS / 2) * (1 << (DATA_W - 6));
    else           v = (POINTS / 2 - k) * (1 << (DATA_W - 7));
    return v[DATA_W-1:0];
  endfunction

endpackage

// File: rtl/qnl_table.sv
module qnl_table
  import qnl_pkg::*;
#(
  parameter int LANE  = 0,
  parameter int DEPTH = POINTS,
  parameter int AW    = IDX_W,
  parameter int DW    = DATA_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = default_entry(LANE, k);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/qnl_seq.sv
module qnl_seq
  import qnl_pkg::*;
#(
  parameter int SW = SYM_W,
  parameter int AW = IDX_W,
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W,
  parameter int CODE = CTRL_CODE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_symbol,
  output logic          idle,
  output logic [AW-1:0] rd_idx,
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] rd_q,
  output logic [DW-1:0] nco_data,
  output logic          data_we,
  output logic [CW-1:0] nco_ctrl,
  output logic          ctrl_we,
  output logic          frame_n,
  output logic          done
);

  localparam logic [CW-1:0] CTRL_WORD = CW'(CODE);

  seq_state_t    state;
  logic [AW-1:0] idx_q;
  logic          unused_sym_hi;

  assign unused_sym_hi = ^in_symbol[SW-1:AW];
  assign idle   = (state == ST_IDLE);
  assign rd_idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx_q    <= '0;
      nco_data <= '0;
      nco_ctrl <= '0;
      data_we  <= 1'b0;
      ctrl_we  <= 1'b0;
      frame_n  <= 1'b1;
      done     <= 1'b0;
    end else begin
      data_we <= 1'b0;
      ctrl_we <= 1'b0;
      done    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            idx_q   <= in_symbol[AW-1:0];
            frame_n <= 1'b0;
            state   <= ST_READ;
          end
        end
        ST_READ: state <= ST_WR_I;
        ST_WR_I: begin
          nco_data <= rd_i;
          data_we  <= 1'b1;
          state    <= ST_WR_Q;
        end
        ST_WR_Q: begin
          nco_data <= rd_q;
          data_we  <= 1'b1;
          state    <= ST_WR_CTRL;
        end
        ST_WR_CTRL: begin
          nco_ctrl <= CTRL_WORD;
          ctrl_we  <= 1'b1;
          state    <= ST_CLOSE;
        end
        ST_CLOSE: begin
          frame_n <= 1'b1;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qam_nco_loader.sv
module qam_nco_loader
  import qnl_pkg::*;
#(
  parameter int SW = SYM_W,
  parameter int AW = IDX_W,
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_symbol,
  output logic          in_ready,
  input  logic          tbl_we,
  input  logic          tbl_sel,
  input  logic [AW-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_wdata,
  output logic [DW-1:0] nco_data,
  output logic          data_we,
  output logic [CW-1:0] nco_ctrl,
  output logic          ctrl_we,
  output logic          frame_n,
  output logic          done
);

  logic          idle;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] lane_rd [LANES];

  assign in_ready = idle;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = tbl_we && idle && (tbl_sel == g[0]);
    qnl_table #(.LANE(g), .DEPTH(1 << AW), .AW(AW), .DW(DW)) u_tab (
      .clk   (clk),
      .we    (lane_we),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (rd_idx),
      .rdata (lane_rd[g])
    );
  end

  qnl_seq #(.SW(SW), .AW(AW), .DW(DW), .CW(CW), .CODE(CTRL_CODE)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_symbol (in_symbol),
    .idle      (idle),
    .rd_idx    (rd_idx),
    .rd_i      (lane_rd[0]),
    .rd_q      (lane_rd[1]),
    .nco_data  (nco_data),
    .data_we   (data_we),
    .nco_ctrl  (nco_ctrl),
    .ctrl_we   (ctrl_we),
    .frame_n   (frame_n),
    .done      (done)
  );

endmodule

// File: rtl/qnl_checker.sv
module qnl_checker
  import qnl_pkg::*;
#(
  parameter int CW = CTRL_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          data_we,
  input logic          ctrl_we,
  input logic [CW-1:0] nco_ctrl,
  input logic          frame_n,
  input logic          done
);

  // R5: strobes never overlap
  p_strobe_mutex_r5: assert property (@(posedge clk) disable iff (rst)
    !(data_we && ctrl_we));

  // R5: control write carries the take-up code
  p_ctrl_code_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |-> (nco_ctrl == CW'(CTRL_CODE)));

  // R3: control write follows exactly two data writes
  p_ctrl_after_data_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |-> ($past(data_we) && $past(data_we, 2)));

  // R6: every strobe inside the framed window
  p_write_framed_r6: assert property (@(posedge clk) disable iff (rst)
    (data_we || ctrl_we) |-> !frame_n);

  // R6: done marks the flag returning high
  p_done_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (frame_n && !$past(frame_n)));

  p_rise_gives_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n) |-> done);

  // R7: not ready while framed, and acceptance opens the frame
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_n |-> !in_ready);

  p_accept_frames_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !frame_n);

endmodule

bind qam_nco_loader qnl_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .data_we  (data_we),
  .ctrl_we  (ctrl_we),
  .nco_ctrl (nco_ctrl),
  .frame_n  (frame_n),
  .done     (done)
);

// File: tb/qam_nco_loader_test.sv
module qam_nco_loader_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_symbol = '0;
  logic        in_ready;
  logic        tbl_we = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic [15:0] nco_data;
  logic        data_we;
  logic [7:0]  nco_ctrl;
  logic        ctrl_we;
  logic        frame_n;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;
  bit compare_on = 0;

  always #2.5 clk = ~clk;

  qam_nco_loader uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_symbol(in_symbol),
    .in_ready(in_ready), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .nco_data(nco_data),
    .data_we(data_we), .nco_ctrl(nco_ctrl), .ctrl_we(ctrl_we),
    .frame_n(frame_n), .done(done)
  );

  task automatic chk(input string tag, input bit ok, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] def_i(input int k);
    int v = (k - 16) * 1024;
    return v[15:0];
  endfunction

  function automatic logic [15:0] def_q(input int k);
    int v = (16 - k) * 512;
    return v[15:0];
  endfunction

  // Behavioural reference model
  logic [15:0] m_ti [32];
  logic [15:0] m_tq [32];
  bit          m_busy;
  int          m_ph;
  int          m_idx;
  logic [15:0] m_data;
  logic [7:0]  m_ctrl;
  bit          m_dwe, m_cwe, m_frame, m_done;

  initial begin
    for (int k = 0; k < 32; k++) begin
      m_ti[k] = def_i(k);
      m_tq[k] = def_q(k);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_ph = 0; m_idx = 0; m_data = '0; m_ctrl = '0;
      m_dwe = 0; m_cwe = 0; m_frame = 1; m_done = 0;
    end else begin
      m_dwe = 0; m_cwe = 0; m_done = 0;
      if (m_busy) begin
        m_ph++;
        case (m_ph)
          2: begin m_dwe = 1; m_data = m_ti[m_idx]; end
          3: begin m_dwe = 1; m_data = m_tq[m_idx]; end
          4: begin m_cwe = 1; m_ctrl = 8'd11; end
          5: begin m_frame = 1; m_done = 1; m_busy = 0; end
          default: ;
        endcase
      end else begin
        if (tbl_we) begin
          if (tbl_sel) m_tq[tbl_addr] = tbl_wdata;
          else         m_ti[tbl_addr] = tbl_wdata;
        end
        if (in_valid) begin
          m_busy = 1; m_ph = 0; m_idx = int'(in_symbol) % 32; m_frame = 0;
        end
      end
    end
  end

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (compare_on && !rst) begin
      chk("R7", in_ready == !m_busy, in_ready, !m_busy, "in_ready");
      chk("R6", frame_n == m_frame, frame_n, m_frame, "frame_n");
      chk("R3", data_we == m_dwe, data_we, m_dwe, "data_we");
      chk("R5", ctrl_we == m_cwe, ctrl_we, m_cwe, "ctrl_we");
      chk("R6", done == m_done, done, m_done, "done");
      chk((m_dwe && m_ph == 3) ? "R4" : "R3", nco_data == m_data, nco_data, m_data, "nco_data");
      chk("R5", nco_ctrl == m_ctrl, nco_ctrl, m_ctrl, "nco_ctrl");
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic load(input bit sel, input int addr, input logic [15:0] val);
    wait_ready();
    tbl_we = 1; tbl_sel = sel; tbl_addr = addr[4:0]; tbl_wdata = val;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // Offer one symbol and capture the transaction at the ports
  task automatic run_sym(input logic [7:0] sym, input string tag,
                         input logic [15:0] ei, input logic [15:0] eq);
    logic [15:0] gi = '0;
    logic [15:0] gq = '0;
    int ndw = 0;
    int kd = 0;
    wait_ready();
    in_valid = 1; in_symbol = sym;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 0;
      if (data_we) begin
        if (ndw == 0) gi = nco_data; else gq = nco_data;
        ndw++;
      end
      if (done && kd == 0) kd = k;
    end
    chk(tag, gi == ei, gi, ei, "in-phase word");
    chk(tag, gq == eq, gq, eq, "quadrature word");
    chk("R3", ndw == 2, ndw, 2, "data writes per symbol");
    chk("R8", kd == 6, kd, 6, "cycles to done");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", frame_n == 1 && in_ready == 1, {frame_n, in_ready}, 2'b11, "flag/ready in reset");
    chk("R1", {data_we, ctrl_we, done} == 3'b000, {data_we, ctrl_we, done}, 0, "strobes in reset");
    chk("R1", nco_data == 0 && nco_ctrl == 0, {nco_data, nco_ctrl}, 0, "buses in reset");
    rst = 0;
    @(negedge clk);
    chk("R1", frame_n == 1 && in_ready == 1 && !data_we && !done, {frame_n, in_ready, data_we, done}, 4'b1100, "first cycle after reset");
    compare_on = 1;

    // R11: power-up contents, several indices
    run_sym(8'd3,  "R11", def_i(3),  def_q(3));
    run_sym(8'd31, "R11", def_i(31), def_q(31));
    run_sym(8'd0,  "R11", def_i(0),  def_q(0));
    run_sym(8'd16, "R11", def_i(16), def_q(16));

    // R9: table writes while idle
    load(0, 5, 16'h1234);
    load(1, 5, 16'hBEEF);
    run_sym(8'd5, "R9", 16'h1234, 16'hBEEF);

    // R2: upper symbol bits ignored
    run_sym(8'hE5, "R2", 16'h1234, 16'hBEEF);
    load(1, 31, 16'h7F00);
    run_sym(8'hFF, "R2", def_i(31), 16'h7F00);
    run_sym(8'h20, "R2", def_i(0), def_q(0));

    // R9: write in the accepting cycle is seen by that symbol
    wait_ready();
    tbl_we = 1; tbl_sel = 0; tbl_addr = 5'd9; tbl_wdata = 16'h0A0A;
    in_valid = 1; in_symbol = 8'd9;
    @(negedge clk);
    tbl_we = 0; in_valid = 0;
    repeat (7) @(negedge clk);
    run_sym(8'd9, "R9", 16'h0A0A, def_q(9));

    // R10 and R7: writes and symbols offered while busy have no effect
    wait_ready();
    in_valid = 1; in_symbol = 8'd7;
    @(negedge clk);
    in_symbol = 8'd12;
    tbl_we = 1; tbl_sel = 0; tbl_addr = 5'd7; tbl_wdata = 16'hAAAA;
    repeat (4) @(negedge clk);
    tbl_sel = 1;
    chk("R7", in_ready == 0, in_ready, 0, "ready low while busy");
    @(negedge clk);
    tbl_we = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    chk("R7", frame_n == 1, frame_n, 1, "no extra acceptance");
    run_sym(8'd7, "R10", def_i(7), def_q(7));

    // R8: back-to-back with valid held high
    begin
      int last = -1;
      int gaps = 0;
      wait_ready();
      in_valid = 1;
      for (int t = 0; t < 40; t++) begin
        in_symbol = 8'(t * 7);
        @(negedge clk);
        if (done) begin
          if (last >= 0) begin
            chk("R8", (t - last) == 6, t - last, 6, "done spacing");
            gaps++;
          end
          last = t;
        end
      end
      in_valid = 0;
      chk("R8", gaps >= 4, gaps, 4, "back-to-back symbols seen");
      repeat (8) @(negedge clk);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Watchdog
  always @(negedge clk) begin
    if (!finished && cycles > 100000) begin
      finished = 1;
      chk("R1", 0, cycles, 100000, "watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule